// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a core's register file and a 32-bit little-endian data memory. It moves byte, halfword and word values between the two. For a load it takes the fetched memory word, the low address bits, the access size and a signed flag. It picks the addressed byte lanes and returns a register-width value, zero-extended or sign-extended according to the flag.

For a store it takes the register value, the size and the low address bits. It returns memory write data with the value copied into every lane the access could touch, plus one write enable per byte lane that marks only the addressed lanes. Stores never sign-extend: only the low byte or halfword of the register is used.

A misaligned halfword or word access raises an alignment error and blocks every write enable. All outputs are registered, so a request presented on one clock edge produces its result on the outputs after that edge.

Top module: `lsAlign`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises with no request, `rspValid`, `alignErr`, `byteEn`, `ldData` and `stData` are all zero.
- R2: A request accepted with `reqValid` high on a clock edge gives `rspValid` high after that edge. A cycle without a request gives `rspValid`, `alignErr` and `byteEn` all zero after the edge, and `ldData` and `stData` keep their previous values.
- R3: An unsigned byte load (`isStore`=0, `size`=00, `signedLd`=0) returns memory bits [8*a+7:8*a] in `ldData[7:0]`, where a = `addrLo`, with bits [31:8] zero. Memory is little-endian, so lane 0 holds the lowest address.
- R4: A signed byte load (`size`=00, `signedLd`=1) returns the same byte with its bit 7 copied into `ldData[31:8]`.
- R5: An unsigned halfword load (`size`=01) at `addrLo` 0 or 2 returns lanes a and a+1 in `ldData[15:0]`, lane a in the low byte, with bits [31:16] zero. For example, bytes EE,FF give 0x0000FFEE.
- R6: A signed halfword load copies `ldData[15]` into `ldData[31:16]`. For example, bytes EE,8C give 0xFFFF8CEE.
- R7: An aligned word load returns the memory word unchanged, and `signedLd` has no effect on it.
- R8: A byte store copies `regWdata[7:0]` into all four lanes of `stData` and sets only `byteEn` bit `addrLo`. `signedLd` has no effect on it.
- R9: A halfword store copies `regWdata[15:0]` into both halves of `stData` and sets `byteEn` to 0011 for `addrLo`=0 and 1100 for `addrLo`=2.
- R10: An aligned word store passes `regWdata` to `stData` unchanged with `byteEn`=1111. For example, 0xFEEDBABE puts BE in lane 0 and FE in lane 3.
- R11: A halfword access with `addrLo[0]`=1, or a word access with `addrLo`≠0, sets `alignErr`, forces `byteEn` to 0000 and forces `ldData` to zero. On a store, `stData` still carries the copied value.
- R12: `size` encodes 00 as byte, 01 as halfword and 10 as word. The value 11 behaves as word.
- R13: A load always gives `byteEn`=0000 and `stData`=0. A store always gives `ldData`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| isStore | input | 1 | 1 = store, 0 = load |
| size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| signedLd | input | 1 | Sign-extend a byte or halfword load |
| addrLo | input | 2 | Low address bits, select the byte lane |
| memRdata | input | 32 | Word read from memory (loads) |
| regWdata | input | 32 | Register value to store |
| rspValid | output | 1 | Result registered for the previous request |
| ldData | output | 32 | Extended load result |
| stData | output | 32 | Lane-copied write data |
| byteEn | output | 4 | Per-lane write enables |
| alignErr | output | 1 | Misaligned halfword or word access |

## Verification
The bench builds the block with its default 32-bit data width, which gives four byte lanes and a two-bit lane address. Every lane offset is therefore reachable for every size. The vector table covers:
- each lane for byte loads and stores,
- both halves for halfword accesses,
- sign bits set and clear,
- the reserved size code,
- every kind of misalignment.

The directed tests cover reset, idle cycles after a response, and a reset applied in the middle of traffic.

// File: rtl/lsaPkg.sv
package lsaPkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } sizeT;

  // strobes from control to datapath
  typedef struct packed {
    logic valid;
    logic load;
    logic store;
    logic selByte;
    logic selHalf;
    logic selWord;
    logic sext;
    logic err;
  } lsaStbT;

endpackage

// File: rtl/lsaCtrl.sv
module lsaCtrl
  import lsaPkg::*;
#(
  parameter int AW = 2
) (
  input  logic          reqValid,
  input  logic          isStore,
  input  logic [1:0]    size,
  input  logic          signedLd,
  input  logic [AW-1:0] addrLo,
  output lsaStbT        stb
);

  logic misHalf;
  logic misWord;

  always_comb begin
    stb = '0;
    stb.valid = reqValid;
    stb.load  = reqValid & ~isStore;
    stb.store = reqValid & isStore;
    unique case (sizeT'(size))
      SZ_BYTE: stb.selByte = 1'b1;
      SZ_HALF: stb.selHalf = 1'b1;
      default: stb.selWord = 1'b1;   // reserved code treated as full width
    endcase
    misHalf  = stb.selHalf & addrLo[0];
    misWord  = stb.selWord & (addrLo != '0);
    stb.err  = reqValid & (misHalf | misWord);
    // stores and full-width loads never extend
    stb.sext = stb.load & signedLd & ~stb.selWord;
  end

endmodule

// File: rtl/lsaDatapath.sv
module lsaDatapath
  import lsaPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NL     = DATA_W / 8,
  parameter int AW     = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsaStbT            stb,
  input  logic [AW-1:0]     addrLo,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] regWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] ldData,
  output logic [DATA_W-1:0] stData,
  output logic [NL-1:0]     byteEn,
  output logic              alignErr
);

  logic [DATA_W-1:0] rdShifted;
  logic [7:0]        rdByte;
  logic [15:0]       rdHalf;
  logic [DATA_W-1:0] ldNext;
  logic [DATA_W-1:0] stRepl;
  logic [NL-1:0]     byteMask;
  logic [NL-1:0]     halfMask;
  logic [NL-1:0]     laneMask;

  // move the addressed lane down to bit 0
  assign rdShifted = memRdata >> {addrLo, 3'b000};
  assign rdByte    = rdShifted[7:0];
  assign rdHalf    = rdShifted[15:0];

  always_comb begin
    if (stb.selByte)
      ldNext = {{(DATA_W-8){stb.sext & rdByte[7]}}, rdByte};
    else if (stb.selHalf)
      ldNext = {{(DATA_W-16){stb.sext & rdHalf[15]}}, rdHalf};
    else
      ldNext = memRdata;
  end

  // lane copy of store data: each lane picks its slice per size
  for (genvar l = 0; l < NL; l++) begin : gLane
    always_comb begin
      if (stb.selByte)
        stRepl[l*8 +: 8] = regWdata[7:0];
      else if (stb.selHalf)
        stRepl[l*8 +: 8] = regWdata[(l%2)*8 +: 8];
      else
        stRepl[l*8 +: 8] = regWdata[l*8 +: 8];
    end
  end

  assign byteMask = {{(NL-1){1'b0}}, 1'b1} << addrLo;
  assign halfMask = {{(NL-2){1'b0}}, 2'b11} << addrLo;

  always_comb begin
    if (stb.selByte)      laneMask = byteMask;
    else if (stb.selHalf) laneMask = halfMask;
    else                  laneMask = {NL{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      alignErr <= 1'b0;
      byteEn   <= '0;
      ldData   <= '0;
      stData   <= '0;
    end else begin
      rspValid <= stb.valid;
      alignErr <= stb.err;
      byteEn   <= (stb.store && !stb.err) ? laneMask : '0;
      if (stb.valid) begin
        ldData <= (stb.load && !stb.err) ? ldNext : '0;
        stData <= stb.store ? stRepl : '0;
      end
    end
  end

endmodule

// File: rtl/lsAlign.sv
module lsAlign
  import lsaPkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NL    = DATA_W / 8,
  localparam int AW    = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              isStore,
  input  logic [1:0]        size,
  input  logic              signedLd,
  input  logic [AW-1:0]     addrLo,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] regWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] ldData,
  output logic [DATA_W-1:0] stData,
  output logic [NL-1:0]     byteEn,
  output logic              alignErr
);

  lsaStbT stb;

  lsaCtrl #(.AW(AW)) uCtrl (
    .reqValid (reqValid),
    .isStore  (isStore),
    .size     (size),
    .signedLd (signedLd),
    .addrLo   (addrLo),
    .stb      (stb)
  );

  lsaDatapath #(.DATA_W(DATA_W), .NL(NL), .AW(AW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addrLo   (addrLo),
    .memRdata (memRdata),
    .regWdata (regWdata),
    .rspValid (rspValid),
    .ldData   (ldData),
    .stData   (stData),
    .byteEn   (byteEn),
    .alignErr (alignErr)
  );

endmodule

// File: rtl/lsAlignChk.sv
module lsAlignChk #(
  parameter int DATA_W = 32,
  localparam int NL    = DATA_W / 8,
  localparam int AW    = $clog2(NL)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              isStore,
  input logic [1:0]        size,
  input logic              signedLd,
  input logic [AW-1:0]     addrLo,
  input logic              rspValid,
  input logic [DATA_W-1:0] ldData,
  input logic [NL-1:0]     byteEn,
  input logic              alignErr
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && byteEn == '0 && !alignErr));  // R2

  AST_ERR_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (byteEn == '0 && ldData == '0));  // R11

  AST_ENABLE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn != '0) |-> ($countones(byteEn) == 1 || $countones(byteEn) == 2 ||
                        $countones(byteEn) == NL));  // R8

  AST_SBYTE_EXTEND: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isStore && size == 2'b00 && signedLd) |=>
      (ldData[DATA_W-1:8] == {(DATA_W-8){ldData[7]}}));  // R4

  AST_UHALF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isStore && size == 2'b01 && !signedLd) |=>
      (ldData[DATA_W-1:16] == '0));  // R5

  AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isStore && size == 2'b01 && !addrLo[0]) |=>
      (byteEn == ({{(NL-2){1'b0}}, 2'b11} << $past(addrLo))));  // R9

  AST_LOAD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isStore) |=> (byteEn == '0));  // R13

endmodule

bind lsAlign lsAlignChk #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .isStore  (isStore),
  .size     (size),
  .signedLd (signedLd),
  .addrLo   (addrLo),
  .rspValid (rspValid),
  .ldData   (ldData),
  .byteEn   (byteEn),
  .alignErr (alignErr)
);

// File: tb/sim_lsAlign.sv
`timescale 1ns/1ps
module sim_lsAlign;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        isStore;
  logic [1:0]  size;
  logic        signedLd;
  logic [1:0]  addrLo;
  logic [31:0] memRdata;
  logic [31:0] regWdata;
  logic        rspValid;
  logic [31:0] ldData;
  logic [31:0] stData;
  logic [3:0]  byteEn;
  logic        alignErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lsAlign #(.DATA_W(32)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isStore(isStore),
    .size(size), .signedLd(signedLd), .addrLo(addrLo),
    .memRdata(memRdata), .regWdata(regWdata), .rspValid(rspValid),
    .ldData(ldData), .stData(stData), .byteEn(byteEn), .alignErr(alignErr)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        st;
    logic [1:0]  sz;
    logic        sg;
    logic [1:0]  ad;
    logic [31:0] mem;
    logic [31:0] rg;
    logic [31:0] expLd;
    logic [31:0] expSt;
    logic [3:0]  expEn;
    logic        expErr;
  } vecT;

  localparam int NV = 23;
  localparam vecT VEC [NV] = '{
    '{8'd3,  1'b0, 2'd0, 1'b0, 2'd0, 32'hA790FFEE, 32'h0, 32'h000000EE, 32'h0, 4'h0, 1'b0}, // R3
    '{8'd4,  1'b0, 2'd0, 1'b1, 2'd0, 32'hA790FFEE, 32'h0, 32'hFFFFFFEE, 32'h0, 4'h0, 1'b0}, // R4
    '{8'd3,  1'b0, 2'd0, 1'b0, 2'd3, 32'hA790FFEE, 32'h0, 32'h000000A7, 32'h0, 4'h0, 1'b0}, // R3
    '{8'd4,  1'b0, 2'd0, 1'b1, 2'd2, 32'hA790FFEE, 32'h0, 32'hFFFFFF90, 32'h0, 4'h0, 1'b0}, // R4
    '{8'd4,  1'b0, 2'd0, 1'b1, 2'd1, 32'h00007F00, 32'h0, 32'h0000007F, 32'h0, 4'h0, 1'b0}, // R4
    '{8'd5,  1'b0, 2'd1, 1'b0, 2'd0, 32'hA790FFEE, 32'h0, 32'h0000FFEE, 32'h0, 4'h0, 1'b0}, // R5
    '{8'd6,  1'b0, 2'd1, 1'b1, 2'd0, 32'hA7908CEE, 32'h0, 32'hFFFF8CEE, 32'h0, 4'h0, 1'b0}, // R6
    '{8'd6,  1'b0, 2'd1, 1'b1, 2'd2, 32'hA7908CEE, 32'h0, 32'hFFFFA790, 32'h0, 4'h0, 1'b0}, // R6
    '{8'd6,  1'b0, 2'd1, 1'b1, 2'd2, 32'h7FFF0000, 32'h0, 32'h00007FFF, 32'h0, 4'h0, 1'b0}, // R6
    '{8'd5,  1'b0, 2'd1, 1'b0, 2'd2, 32'hA7908CEE, 32'h0, 32'h0000A790, 32'h0, 4'h0, 1'b0}, // R5
    '{8'd7,  1'b0, 2'd2, 1'b1, 2'd0, 32'hA790FFEE, 32'h0, 32'hA790FFEE, 32'h0, 4'h0, 1'b0}, // R7
    '{8'd12, 1'b0, 2'd3, 1'b0, 2'd0, 32'h12345678, 32'h0, 32'h12345678, 32'h0, 4'h0, 1'b0}, // R12
    '{8'd10, 1'b1, 2'd2, 1'b0, 2'd0, 32'h0, 32'hFEEDBABE, 32'h0, 32'hFEEDBABE, 4'hF, 1'b0}, // R10
    '{8'd8,  1'b1, 2'd0, 1'b0, 2'd0, 32'h0, 32'h123456C3, 32'h0, 32'hC3C3C3C3, 4'h1, 1'b0}, // R8
    '{8'd8,  1'b1, 2'd0, 1'b0, 2'd3, 32'h0, 32'h123456C3, 32'h0, 32'hC3C3C3C3, 4'h8, 1'b0}, // R8
    '{8'd8,  1'b1, 2'd0, 1'b1, 2'd1, 32'h0, 32'h000000F0, 32'h0, 32'hF0F0F0F0, 4'h2, 1'b0}, // R8
    '{8'd9,  1'b1, 2'd1, 1'b0, 2'd0, 32'h0, 32'hABCD1234, 32'h0, 32'h12341234, 4'h3, 1'b0}, // R9
    '{8'd9,  1'b1, 2'd1, 1'b1, 2'd2, 32'h0, 32'h0000BEEF, 32'h0, 32'hBEEFBEEF, 4'hC, 1'b0}, // R9
    '{8'd11, 1'b1, 2'd1, 1'b0, 2'd1, 32'h0, 32'hABCD1234, 32'h0, 32'h12341234, 4'h0, 1'b1}, // R11
    '{8'd11, 1'b1, 2'd2, 1'b0, 2'd2, 32'h0, 32'hFEEDBABE, 32'h0, 32'hFEEDBABE, 4'h0, 1'b1}, // R11
    '{8'd11, 1'b0, 2'd2, 1'b0, 2'd1, 32'hA790FFEE, 32'h0, 32'h0, 32'h0, 4'h0, 1'b1},        // R11
    '{8'd11, 1'b0, 2'd1, 1'b1, 2'd3, 32'hA790FFEE, 32'h0, 32'h0, 32'h0, 4'h0, 1'b1},        // R11
    '{8'd3,  1'b0, 2'd0, 1'b0, 2'd1, 32'hA790FFEE, 32'h0, 32'h000000FF, 32'h0, 4'h0, 1'b0}  // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkIdleZero(input string tag);
    check({tag, " rspValid"}, {31'b0, rspValid}, 32'h0);
    check({tag, " alignErr"}, {31'b0, alignErr}, 32'h0);
    check({tag, " byteEn"},   {28'b0, byteEn},   32'h0);
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic sg,
                       input logic [1:0] ad, input logic [31:0] mem,
                       input logic [31:0] rg);
    reqValid = 1'b1; isStore = st; size = sz; signedLd = sg;
    addrLo = ad; memRdata = mem; regWdata = rg;
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; isStore = 1'b0; size = 2'b00;
    signedLd = 1'b0; addrLo = 2'b00; memRdata = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, no request yet
    checkIdleZero("R1");
    check("R1 ldData", ldData, 32'h0);
    check("R1 stData", stData, 32'h0);

    // table walk, back-to-back requests
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].st, VEC[i].sz, VEC[i].sg, VEC[i].ad, VEC[i].mem, VEC[i].rg);
      @(negedge clk);
      nChecks++;
      if (rspValid !== 1'b1 || ldData !== VEC[i].expLd || stData !== VEC[i].expSt ||
          byteEn !== VEC[i].expEn || alignErr !== VEC[i].expErr) begin
        nFails++;
        $display("FAIL R%0d vec %0d actual ld=%h st=%h en=%h err=%b rsp=%b expected ld=%h st=%h en=%h err=%b rsp=1",
                 VEC[i].req, i, ldData, stData, byteEn, alignErr, rspValid,
                 VEC[i].expLd, VEC[i].expSt, VEC[i].expEn, VEC[i].expErr);
      end
    end

    // R2: idle cycle after a valid load keeps data, clears strobes
    drive(1'b0, 2'd1, 1'b1, 2'd0, 32'hA7908CEE, 32'h0);
    @(negedge clk);
    check("R6 directed", ldData, 32'hFFFF8CEE);
    reqValid = 1'b0; memRdata = 32'h0;
    @(negedge clk);
    checkIdleZero("R2 idle");
    check("R2 ldData hold", ldData, 32'hFFFF8CEE);

    // R13: aligned word load gives no enables, zero store data
    drive(1'b0, 2'd2, 1'b0, 2'd0, 32'h55AA55AA, 32'hFFFFFFFF);
    @(negedge clk);
    check("R13 byteEn", {28'b0, byteEn}, 32'h0);
    check("R13 stData", stData, 32'h0);

    // R13: store gives zero load data
    drive(1'b1, 2'd2, 1'b0, 2'd0, 32'h55AA55AA, 32'h01020304);
    @(negedge clk);
    check("R13 ldData", ldData, 32'h0);
    check("R10 stData", stData, 32'h01020304);

    // R1: reset in the middle of traffic clears every output
    drive(1'b1, 2'd0, 1'b0, 2'd2, 32'h0, 32'h000000AB);
    rstN = 1'b0;
    @(negedge clk);
    checkIdleZero("R1 midreset");
    check("R1 midreset stData", stData, 32'h0);
    check("R1 midreset ldData", ldData, 32'h0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkIdleZero("R2 after reset");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule